// File: doc/BRIEF.md
# Low-Privilege Counter and Timer Access Trap Checker

This block decides, for each attempt by the least-privileged software level to touch a counter or timer system register, whether the access must trap and where the trap is delivered. The access is described by a small register identifier, the execution-state width and the transfer width. It is judged against four access-enable bits and the hypervisor context flags. The block does not decode instructions and does not enter exceptions. It supplies a trap flag, a target level and an exception-class syndrome code to the logic that does.

The verdict is registered. It appears one cycle after the access-valid strobe and sits beside a registered valid flag. Identifier encoding: 0 = physical timer group (control, compare and value registers), 1 = virtual timer group, 2 = physical count, 3 = virtual count, 4 = frequency, and 5 to 7 are not counter or timer registers.

Top module: `tmr_access_trap`

## Requirements
- R1: With `en_ptimer_i` = 0, an access to identifier 0 traps. With it at 1, that access does not trap.
- R2: With `en_vtimer_i` = 0, an access to identifier 1 traps. With it at 1, that access does not trap.
- R3: Identifier 2 traps exactly when `en_pcount_i` = 0, and identifier 3 traps exactly when `en_vcount_i` = 0.
- R4: Identifier 4 (frequency) traps only when `en_pcount_i` and `en_vcount_i` are both 0.
- R5: A trapped access made in 64-bit state (`acc_aa64_i` = 1) reports syndrome 0x18.
- R6: A trapped access made in 32-bit state reports 0x03 for a single-register move (`acc_pair_i` = 0) and 0x04 for a register-pair move (`acc_pair_i` = 1).
- R7: `to_hyp_o` is 1 for a trap when `hyp_on_i` and `hyp_tge_i` are both 1. Otherwise it is 0, meaning the kernel level. It is 0 whenever no trap is flagged.
- R8: With `hyp_e2h_i` and `hyp_tge_i` both 1, no access traps, whatever the enables are.
- R9: `rsp_valid_o`, `trap_o`, `to_hyp_o` and `syndrome_o` reflect the inputs sampled on the previous rising edge. With no strobe in that cycle, all four are 0.
- R10: Identifiers 5 to 7 never produce a trap.
- R11: While reset is held, and on the first cycle after it is released, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid_i | input | 1 | Access-valid strobe |
| acc_reg_i | input | 3 | Register identifier |
| acc_aa64_i | input | 1 | 1 = access made in 64-bit execution state |
| acc_pair_i | input | 1 | 1 = 64-bit register-pair move (meaningful in 32-bit state) |
| en_pcount_i | input | 1 | Physical count access enable |
| en_vcount_i | input | 1 | Virtual count access enable |
| en_ptimer_i | input | 1 | Physical timer access enable |
| en_vtimer_i | input | 1 | Virtual timer access enable |
| hyp_on_i | input | 1 | Hypervisor level implemented and enabled |
| hyp_tge_i | input | 1 | Route general exceptions to the hypervisor |
| hyp_e2h_i | input | 1 | Host runs at the hypervisor level |
| rsp_valid_o | output | 1 | Verdict valid |
| trap_o | output | 1 | Access traps |
| to_hyp_o | output | 1 | Trap target: 1 = hypervisor, 0 = kernel |
| syndrome_o | output | 6 | Exception class of the trap, 0 when no trap |

## Verification
The frequency identifier is driven with all four combinations of the two count enables. A design that traps it when only one enable is clear, as plain count accesses do, fails there. The host flags are exercised with each of `hyp_e2h_i` and `hyp_tge_i` set alone and with both set. Only both set may suppress the trap, and with `hyp_tge_i` alone the trap must go to the hypervisor, so a design that tests one flag misroutes or drops traps. Syndrome checks cover both states and both transfer widths, which catches a design that swaps 0x03 and 0x04 or ignores the state width. Identifiers 5 to 7 are sent with every enable clear, and idle cycles follow trapping accesses, so a stale or over-broad decode shows up as a spurious trap.

// File: rtl/tmr_access_trap.sv
module tmr_access_trap #(
  parameter int ID_W  = 3,
  parameter int SYN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid_i,
  input  logic [ID_W-1:0]  acc_reg_i,
  input  logic             acc_aa64_i,
  input  logic             acc_pair_i,
  input  logic             en_pcount_i,
  input  logic             en_vcount_i,
  input  logic             en_ptimer_i,
  input  logic             en_vtimer_i,
  input  logic             hyp_on_i,
  input  logic             hyp_tge_i,
  input  logic             hyp_e2h_i,
  output logic             rsp_valid_o,
  output logic             trap_o,
  output logic             to_hyp_o,
  output logic [SYN_W-1:0] syndrome_o
);
  localparam logic [ID_W-1:0]  ID_PTIMER = ID_W'(0);
  localparam logic [ID_W-1:0]  ID_VTIMER = ID_W'(1);
  localparam logic [ID_W-1:0]  ID_PCOUNT = ID_W'(2);
  localparam logic [ID_W-1:0]  ID_VCOUNT = ID_W'(3);
  localparam logic [ID_W-1:0]  ID_FREQ   = ID_W'(4);
  localparam logic [SYN_W-1:0] EC_WIDE   = SYN_W'(8'h18);
  localparam logic [SYN_W-1:0] EC_CP32   = SYN_W'(8'h03);
  localparam logic [SYN_W-1:0] EC_CP64   = SYN_W'(8'h04);

  logic             blocked;
  logic             host_mode;
  logic             trap_d;
  logic             hyp_d;
  logic [SYN_W-1:0] syn_d;

  always_comb begin
    unique case (acc_reg_i)
      ID_PTIMER: blocked = ~en_ptimer_i;
      ID_VTIMER: blocked = ~en_vtimer_i;
      ID_PCOUNT: blocked = ~en_pcount_i;
      ID_VCOUNT: blocked = ~en_vcount_i;
      ID_FREQ:   blocked = ~(en_pcount_i | en_vcount_i);
      default:   blocked = 1'b0;
    endcase
  end

  assign host_mode = hyp_e2h_i & hyp_tge_i;
  assign trap_d    = acc_valid_i & blocked & ~host_mode;
  assign hyp_d     = trap_d & hyp_on_i & hyp_tge_i;
  assign syn_d     = !trap_d    ? '0 :
                     acc_aa64_i ? EC_WIDE :
                     acc_pair_i ? EC_CP64 : EC_CP32;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      trap_o      <= 1'b0;
      to_hyp_o    <= 1'b0;
      syndrome_o  <= '0;
    end else begin
      rsp_valid_o <= acc_valid_i;
      trap_o      <= trap_d;
      to_hyp_o    <= hyp_d;
      syndrome_o  <= syn_d;
    end
  end
endmodule

module tmr_access_trap_chk #(
  parameter int ID_W  = 3,
  parameter int SYN_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid_i,
  input logic [ID_W-1:0]  acc_reg_i,
  input logic             acc_aa64_i,
  input logic             acc_pair_i,
  input logic             en_pcount_i,
  input logic             en_vcount_i,
  input logic             en_ptimer_i,
  input logic             en_vtimer_i,
  input logic             hyp_on_i,
  input logic             hyp_tge_i,
  input logic             hyp_e2h_i,
  input logic             rsp_valid_o,
  input logic             trap_o,
  input logic             to_hyp_o,
  input logic [SYN_W-1:0] syndrome_o
);
  p_syn_wide_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_o && $past(acc_aa64_i)) |-> syndrome_o == SYN_W'(8'h18));

  p_syn_narrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_o && !$past(acc_aa64_i)) |->
      syndrome_o == ($past(acc_pair_i) ? SYN_W'(8'h04) : SYN_W'(8'h03)));

  p_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (to_hyp_o == $past(hyp_on_i && hyp_tge_i)));

  p_host_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hyp_e2h_i && hyp_tge_i) |-> !trap_o);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid_o |-> (!trap_o && !to_hyp_o && syndrome_o == '0));

  p_bad_id_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc_valid_i) && $past(acc_reg_i) > ID_W'(4)) |-> !trap_o);
endmodule

bind tmr_access_trap tmr_access_trap_chk #(.ID_W(ID_W), .SYN_W(SYN_W)) u_chk (.*);

// File: tb/tmr_access_trap_test.sv
`timescale 1ns/1ps
module tmr_access_trap_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid_i = 1'b0;
  logic [2:0] acc_reg_i = '0;
  logic       acc_aa64_i = 1'b0, acc_pair_i = 1'b0;
  logic       en_pcount_i = 1'b0, en_vcount_i = 1'b0, en_ptimer_i = 1'b0, en_vtimer_i = 1'b0;
  logic       hyp_on_i = 1'b0, hyp_tge_i = 1'b0, hyp_e2h_i = 1'b0;
  logic       rsp_valid_o, trap_o, to_hyp_o;
  logic [5:0] syndrome_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr_access_trap uut (.*);

  function automatic bit exp_trap(bit v, bit [2:0] id, bit pc, bit vc, bit pt, bit vt,
                                  bit e2h, bit tge);
    bit b;
    case (id)
      3'd0: b = !pt;
      3'd1: b = !vt;
      3'd2: b = !pc;
      3'd3: b = !vc;
      3'd4: b = !pc && !vc;
      default: b = 1'b0;
    endcase
    return v && b && !(e2h && tge);
  endfunction

  function automatic string trap_tag(bit v, bit [2:0] id, bit e2h, bit tge);
    if (!v) return "R9";
    if (e2h && tge) return "R8";
    case (id)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2, 3'd3: return "R3";
      3'd4: return "R4";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic access(bit v, bit [2:0] id, bit a64, bit pair, bit pc, bit vc,
                        bit pt, bit vt, bit hon, bit tge, bit e2h);
    bit t;
    acc_valid_i = v; acc_reg_i = id; acc_aa64_i = a64; acc_pair_i = pair;
    en_pcount_i = pc; en_vcount_i = vc; en_ptimer_i = pt; en_vtimer_i = vt;
    hyp_on_i = hon; hyp_tge_i = tge; hyp_e2h_i = e2h;
    @(posedge clk);
    @(negedge clk);
    t = exp_trap(v, id, pc, vc, pt, vt, e2h, tge);
    check("R9", "valid", rsp_valid_o, v);
    check(trap_tag(v, id, e2h, tge), "trap", trap_o, t);
    check("R7", "target", to_hyp_o, t && hon && tge);
    check(a64 ? "R5" : "R6", "syndrome", syndrome_o,
          !t ? 0 : a64 ? 'h18 : pair ? 'h04 : 'h03);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    acc_valid_i = 1'b1; en_ptimer_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11", "valid in reset", rsp_valid_o, 0);
    check("R11", "trap in reset", trap_o, 0);
    check("R11", "syndrome in reset", syndrome_o, 0);
    acc_valid_i = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "trap after reset", trap_o, 0);
    check("R11", "target after reset", to_hyp_o, 0);

    // R4 frequency: all four count enable combinations
    for (int k = 0; k < 4; k++) access(1, 3'd4, 1, 0, k[0], k[1], 1, 1, 0, 0, 0);
    // R3 counts: one enable clear at a time
    access(1, 3'd2, 1, 0, 0, 1, 1, 1, 0, 0, 0);
    access(1, 3'd3, 1, 0, 0, 1, 1, 1, 0, 0, 0);
    access(1, 3'd3, 1, 0, 1, 0, 1, 1, 0, 0, 0);
    // R1/R2 timers
    access(1, 3'd0, 0, 0, 1, 1, 0, 1, 0, 0, 0);
    access(1, 3'd1, 0, 1, 1, 1, 0, 1, 0, 0, 0);
    access(1, 3'd1, 0, 1, 1, 1, 1, 0, 0, 0, 0);
    // R6 both transfer widths in 32-bit state
    access(1, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    access(1, 3'd0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    // R7 / R8 host flag combinations
    access(1, 3'd0, 1, 0, 0, 0, 0, 0, 1, 1, 0);
    access(1, 3'd0, 1, 0, 0, 0, 0, 0, 0, 1, 0);
    access(1, 3'd0, 1, 0, 0, 0, 0, 0, 1, 0, 1);
    access(1, 3'd0, 1, 0, 0, 0, 0, 0, 1, 1, 1);
    // R10 unlisted identifiers with everything clear
    for (int id = 5; id < 8; id++) access(1, 3'(id), 0, 1, 0, 0, 0, 0, 1, 1, 0);
    // R9 idle after a trapping access
    access(1, 3'd2, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    access(0, 3'd2, 1, 0, 0, 0, 0, 0, 0, 0, 0);

    for (int n = 0; n < 3000; n++) begin
      bit [31:0] r;
      r = $urandom();
      access(r[0] | r[1], r[4:2], r[5], r[6], r[7], r[8], r[9], r[10],
             r[11], r[12], r[13] & r[14]);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule